// File: doc/BRIEF.md
# Per-Rank DRAM Activate Pacing Unit

This unit decides, cycle by cycle, whether an ACTIVATE may be sent to a given bank of a given rank. It enforces two pacing rules. The first is a minimum gap of tRRD cycles between activates to the same rank. The second is a rolling window: no rank may receive more than a programmed number of activates within any span of tXAW cycles. A window of four activates suits four-activate-window devices, and a window of two suits two-activate-window devices. The window is tracked separately for every rank, so a busy rank never holds back its neighbours.

A scheduler reports every activate it sends with `act_valid`, a rank and a bank. It asks about any rank and bank through the query port, and `qry_allowed` answers combinationally from the state left by earlier cycles. The unit keeps an earliest-activate counter for each bank, apart from any bank-busy tracking, so pacing activates never delays column or precharge traffic. The window history of each rank is a short shift register of elapsed-cycle counters. If an activate is sent while the unit reports it as not allowed, the activate is still recorded and a sticky error flag rises. The rank and bank counts must be powers of two, at least two each.

Top module: `act_rate_limiter`

## Requirements
- R1: After reset, every rank and bank queries as allowed and `err_early_act` is 0.
- R2: An activate to rank r in cycle c makes every bank of rank r query as not allowed in cycles c+1 through c+`cfg_trrd`-1, provided the window rule permits it. A `cfg_trrd` of 0 or 1 imposes no gap.
- R3: With an effective limit L between 1 and 4, a rank that has had L or more activates is allowed in cycle t only if t minus the cycle of its L-th most recent activate is at least `cfg_txaw`.
- R4: A limit of 4 behaves as a four-activate window and a limit of 2 as a two-activate window. Any `cfg_act_limit` above WIN_DEPTH (4) acts as 4.
- R5: A `cfg_act_limit` of 0 disables the window rule, so only the R2 gap applies.
- R6: Activates to one rank never change whether another rank is allowed.
- R7: An activate whose own rank and bank query as not allowed in that cycle sets `err_early_act` from the next cycle onward, and it stays set until reset. Allowed activates never set it.
- R8: An activate issued in cycle c affects `qry_allowed` only from cycle c+1 onward. In cycle c the answer still reflects the earlier state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_txaw | input | 16 | Rolling window length in cycles |
| cfg_trrd | input | 16 | Minimum gap between activates to one rank |
| cfg_act_limit | input | 3 | Activates allowed per window; 0 disables the window |
| act_valid | input | 1 | An activate is issued this cycle |
| act_rank | input | 1 | Rank of the issued activate |
| act_bank | input | 3 | Bank of the issued activate |
| qry_rank | input | 1 | Rank being asked about |
| qry_bank | input | 3 | Bank being asked about |
| qry_allowed | output | 1 | The queried bank may be activated this cycle |
| err_early_act | output | 1 | Sticky flag: an activate was issued while not allowed |

## Verification
Each configuration sweeps window limits 0, 1, 2, 3, 4 and 6 against gaps 0, 1 and 3 and two window lengths. Within it, one rank activates greedily, as early as the pacing rules permit, which pins the exact release cycle of both the gap rule and the window rule. A second rank activates sparsely and cuts into the greedy stream, which separates true per-rank windows from one shared window. Every one of the sixteen rank and bank queries is compared each cycle, including the cycle in which an activate is issued. A final early activate shows that the error flag rises and then holds.

// File: rtl/arl_pkg.sv
package arl_pkg;

  localparam int TICK_W = 16;

  typedef logic [TICK_W-1:0] tick_t;

  // Elapsed-cycle increment that holds at the top value instead of wrapping.
  function automatic tick_t sat_inc(input tick_t v);
    return (v == '1) ? v : v + tick_t'(1);
  endfunction

endpackage

// File: rtl/arl_rank_window.sv
// Rolling activate window for one rank: a shift history of elapsed-cycle
// counters, newest in slot 0. Slot k holds the age of the (k+1)-th most
// recent activate.
module arl_rank_window
  import arl_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LIM_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_en,
  input  tick_t            cfg_txaw,
  input  logic [LIM_W-1:0] cfg_limit,
  output logic             win_ok
);

  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] vld_d;
  logic [DEPTH-1:0] slot_en;
  tick_t            age_q [DEPTH];
  tick_t            age_d [DEPTH];

  logic [LIM_W-1:0] eff_lim;
  logic             sel_vld;
  tick_t            sel_age;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    if (g == 0) begin : g_head
      always_comb begin
        if (act_en) begin
          vld_d[g] = 1'b1;
          age_d[g] = tick_t'(1);
        end else begin
          vld_d[g] = vld_q[g];
          age_d[g] = sat_inc(age_q[g]);
        end
      end
    end else begin : g_tail
      always_comb begin
        if (act_en) begin
          vld_d[g] = vld_q[g-1];
          age_d[g] = sat_inc(age_q[g-1]);
        end else begin
          vld_d[g] = vld_q[g];
          age_d[g] = sat_inc(age_q[g]);
        end
      end
    end

    assign slot_en[g] = act_en | vld_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        age_q[g] <= '0;
      end else if (slot_en[g]) begin
        vld_q[g] <= vld_d[g];
        age_q[g] <= age_d[g];
      end
    end
  end

  // Limits beyond the history depth behave as the full depth.
  assign eff_lim = (cfg_limit > LIM_W'(DEPTH)) ? LIM_W'(DEPTH) : cfg_limit;

  always_comb begin
    sel_vld = 1'b0;
    sel_age = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (LIM_W'(i + 1) == eff_lim) begin
        sel_vld = vld_q[i];
        sel_age = age_q[i];
      end
    end
  end

  assign win_ok = (eff_lim == '0) || !sel_vld || (sel_age >= cfg_txaw);

endmodule

// File: rtl/arl_bank_gap.sv
// Earliest-activate counter for one bank: counts down the cycles left
// before another activate may be issued, and is kept apart from busy state.
module arl_bank_gap
  import arl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  tick_t load_val,
  output logic  ready
);

  tick_t cnt_q;
  tick_t cnt_d;
  logic  cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - tick_t'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ready = (cnt_q == '0);

endmodule

// File: rtl/act_rate_limiter.sv
module act_rate_limiter
  import arl_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int NUM_BANKS = 8,
  parameter int WIN_DEPTH = 4,
  parameter int LIM_W     = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [TICK_W-1:0]            cfg_txaw,
  input  logic [TICK_W-1:0]            cfg_trrd,
  input  logic [LIM_W-1:0]             cfg_act_limit,
  input  logic                         act_valid,
  input  logic [$clog2(NUM_RANKS)-1:0] act_rank,
  input  logic [$clog2(NUM_BANKS)-1:0] act_bank,
  input  logic [$clog2(NUM_RANKS)-1:0] qry_rank,
  input  logic [$clog2(NUM_BANKS)-1:0] qry_bank,
  output logic                         qry_allowed,
  output logic                         err_early_act
);

  localparam int RANK_W = $clog2(NUM_RANKS);
  localparam int BANK_W = $clog2(NUM_BANKS);

  logic [NUM_RANKS-1:0] rank_act;
  logic [NUM_RANKS-1:0] win_ok;
  logic [NUM_BANKS-1:0] bank_rdy [NUM_RANKS];
  tick_t                gap_load;

  logic act_ok;
  logic qry_win_ok;
  logic err_d;
  logic err_en;

  // The gap counter reads zero once cfg_trrd cycles have passed.
  assign gap_load = (cfg_trrd == '0) ? '0 : (cfg_trrd - tick_t'(1));

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    assign rank_act[r] = act_valid && (act_rank == RANK_W'(r));

    arl_rank_window #(
      .DEPTH (WIN_DEPTH),
      .LIM_W (LIM_W)
    ) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_en    (rank_act[r]),
      .cfg_txaw  (cfg_txaw),
      .cfg_limit (cfg_act_limit),
      .win_ok    (win_ok[r])
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      arl_bank_gap u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rank_act[r]),
        .load_val (gap_load),
        .ready    (bank_rdy[r][b])
      );
    end
  end

  assign act_ok      = bank_rdy[act_rank][act_bank] && win_ok[act_rank];
  assign qry_win_ok  = win_ok[qry_rank];
  assign qry_allowed = bank_rdy[qry_rank][qry_bank] && qry_win_ok;

  // Sticky record of an activate issued against the pacing rules.
  always_comb begin
    err_en = act_valid && !act_ok;
    err_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_early_act <= 1'b0;
    end else if (err_en) begin
      err_early_act <= err_d;
    end
  end

endmodule

// File: rtl/arl_checker.sv
module arl_checker #(
  parameter int RANK_W = 1,
  parameter int BANK_W = 3,
  parameter int LIM_W  = 3,
  parameter int TW     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TW-1:0]     cfg_txaw,
  input logic [TW-1:0]     cfg_trrd,
  input logic [LIM_W-1:0]  cfg_act_limit,
  input logic              act_valid,
  input logic [RANK_W-1:0] act_rank,
  input logic [BANK_W-1:0] act_bank,
  input logic [RANK_W-1:0] qry_rank,
  input logic [BANK_W-1:0] qry_bank,
  input logic              qry_allowed,
  input logic              err_early_act,
  input logic              act_ok,
  input logic              qry_win_ok
);

  // R2: the cycle after an activate, its rank is blocked when the gap exceeds one.
  a_r2_gap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && (cfg_trrd > TW'(1))) |=>
      ((qry_rank != $past(act_rank)) || !qry_allowed));

  // R3: a one-activate window blocks the very next cycle when the window exceeds one.
  a_r3_single_window: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && (cfg_act_limit == LIM_W'(1)) && (cfg_txaw > TW'(1))) |=>
      ((qry_rank != $past(act_rank)) || !$stable(cfg_act_limit) ||
       !$stable(cfg_txaw) || !qry_allowed));

  // R5: a zero limit leaves the window rule open for every rank.
  a_r5_no_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_act_limit == '0) |-> qry_win_ok);

  // R6: an activate to another rank cannot take away permission.
  a_r6_rank_isolation: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && qry_allowed && (qry_rank != act_rank)) |=>
      (!$stable(qry_rank) || !$stable(qry_bank) || !$stable(cfg_txaw) ||
       !$stable(cfg_act_limit) || qry_allowed));

  // R7: an early activate raises the flag.
  a_r7_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !act_ok) |=> err_early_act);

  // R7: the flag holds until reset.
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_early_act |=> err_early_act);

endmodule

bind act_rate_limiter arl_checker #(
  .RANK_W (RANK_W),
  .BANK_W (BANK_W),
  .LIM_W  (LIM_W),
  .TW     (TICK_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_txaw      (cfg_txaw),
  .cfg_trrd      (cfg_trrd),
  .cfg_act_limit (cfg_act_limit),
  .act_valid     (act_valid),
  .act_rank      (act_rank),
  .act_bank      (act_bank),
  .qry_rank      (qry_rank),
  .qry_bank      (qry_bank),
  .qry_allowed   (qry_allowed),
  .err_early_act (err_early_act),
  .act_ok        (act_ok),
  .qry_win_ok    (qry_win_ok)
);

// File: tb/act_rate_limiter_test.sv
module act_rate_limiter_test;
  timeunit 1ns;
  timeprecision 10ps;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_txaw;
  logic [15:0] cfg_trrd;
  logic [2:0]  cfg_act_limit;
  logic        act_valid;
  logic        act_rank;
  logic [2:0]  act_bank;
  logic        qry_rank;
  logic [2:0]  qry_bank;
  logic        qry_allowed;
  logic        err_early_act;

  always #(CLK_PERIOD / 2) clk = ~clk;

  act_rate_limiter uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_txaw      (cfg_txaw),
    .cfg_trrd      (cfg_trrd),
    .cfg_act_limit (cfg_act_limit),
    .act_valid     (act_valid),
    .act_rank      (act_rank),
    .act_bank      (act_bank),
    .qry_rank      (qry_rank),
    .qry_bank      (qry_bank),
    .qry_allowed   (qry_allowed),
    .err_early_act (err_early_act)
  );

  int n_run  = 0;
  int n_fail = 0;
  int cyc;
  int last_act [2];
  int hist     [2][4];
  int hcnt     [2];
  bit m_err;
  int m_trrd, m_txaw, m_lim;
  bit after_reset;

  function automatic bit m_gap(input int r);
    return (last_act[r] < 0) || (cyc - last_act[r] >= m_trrd);
  endfunction

  function automatic bit m_win(input int r);
    int l;
    l = (m_lim > 4) ? 4 : m_lim;
    if (l == 0) return 1'b1;
    if (hcnt[r] < l) return 1'b1;
    return (cyc - hist[r][l-1]) >= m_txaw;
  endfunction

  function automatic bit m_ok(input int r);
    return m_gap(r) && m_win(r);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s lim=%0d trrd=%0d txaw=%0d cyc=%0d actual=%0b expected=%0b",
               tag, what, m_lim, m_trrd, m_txaw, cyc, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, sweep all queries, then advance.
  task automatic tick(input bit go, input int r, input int b);
    bit ok_act;
    string tag;
    act_valid = go;
    act_rank  = 1'(r);
    act_bank  = 3'(b);
    for (int qr = 0; qr < 2; qr++) begin
      for (int qb = 0; qb < 8; qb++) begin
        qry_rank = 1'(qr);
        qry_bank = 3'(qb);
        #0.25;
        if (after_reset)                 tag = "R1";
        else if (go && qr == r)          tag = "R8";
        else if (!m_gap(qr))             tag = "R2";
        else if (!m_win(qr))             tag = (m_lim == 2 || m_lim >= 4) ? "R4" : "R3";
        else if (qr == 1 && !m_ok(0))    tag = "R6";
        else if (m_lim == 0)             tag = "R5";
        else                             tag = "R3";
        check(tag, qry_allowed, m_ok(qr), $sformatf("query r%0d b%0d", qr, qb));
      end
    end
    if (after_reset) check("R1", err_early_act, 1'b0, "flag after reset");
    after_reset = 1'b0;
    ok_act = m_ok(r);
    @(posedge clk);
    if (go) begin
      if (!ok_act) m_err = 1'b1;
      for (int k = 3; k > 0; k--) hist[r][k] = hist[r][k-1];
      hist[r][0]  = cyc;
      hcnt[r]     = (hcnt[r] < 4) ? hcnt[r] + 1 : 4;
      last_act[r] = cyc;
    end
    cyc++;
    @(negedge clk);
    act_valid = 1'b0;
    check("R7", err_early_act, m_err, "error flag");
  endtask

  task automatic do_reset(input int lim, input int trrd, input int txaw);
    @(negedge clk);
    rst_n         = 1'b0;
    act_valid     = 1'b0;
    cfg_act_limit = 3'(lim);
    cfg_trrd      = 16'(trrd);
    cfg_txaw      = 16'(txaw);
    m_lim = lim; m_trrd = trrd; m_txaw = txaw;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    m_err = 1'b0;
    for (int r = 0; r < 2; r++) begin
      last_act[r] = -1;
      hcnt[r] = 0;
    end
    after_reset = 1'b1;
  endtask

  initial begin
    int lims [6];
    int gaps [3];
    int wins [2];
    bit done;
    lims = '{0, 1, 2, 3, 4, 6};
    gaps = '{0, 1, 3};
    wins = '{5, 12};
    rst_n = 1'b0; act_valid = 1'b0; act_rank = 1'b0; act_bank = '0;
    qry_rank = 1'b0; qry_bank = '0; cfg_txaw = '0; cfg_trrd = '0; cfg_act_limit = '0;
    after_reset = 1'b0; m_err = 1'b0; cyc = 0;
    foreach (lims[li]) foreach (gaps[gi]) foreach (wins[wi]) begin
      do_reset(lims[li], gaps[gi], wins[wi]);
      tick(1'b0, 0, 0);
      // Greedy stream on rank 0, sparse interleave on rank 1.
      for (int k = 0; k < 40; k++) begin
        if ((cyc % 5) == 0 && m_ok(1)) tick(1'b1, 1, k % 8);
        else if (m_ok(0))              tick(1'b1, 0, k % 8);
        else                           tick(1'b0, 0, 0);
      end
      // One early activate, then confirm the flag holds.
      done = 1'b0;
      for (int k = 0; k < 12 && !done; k++) begin
        if (!m_ok(0)) begin
          tick(1'b1, 0, 3);
          done = 1'b1;
        end else begin
          tick(1'b1, 0, k % 8);
        end
      end
      repeat (3) tick(1'b0, 0, 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule